// File: doc/BRIEF.md
# T1 Transmit Channel Timing Generator

This block follows a T1 transmit frame bit by bit and derives the per-channel timing strobes that the logic around a framer needs. It is clocked by the 1.544 MHz bit clock. A position counter runs across the 193 bit times of a frame. Position 0 is the framing bit. Positions 1 to 192 carry 24 channels of 8 bits each, with the most significant bit of each channel sent first. A one-cycle frame-sync input pulls the counter back to the framing bit. Without that pulse, the counter wraps on its own.

From the counter position the block drives three strobes:
- A channel clock, high during the last bit (the LSB) of each channel.
- A channel-gating output, whose level in each channel comes from a 24-bit mask that software writes.
- A data-link demand clock at either 4 kHz or 2 kHz.

The block also samples the serial data input on the falling edge of the bit clock. It presents that bit together with the current channel number and bit index, so downstream logic can place it in the frame.

Top module: `t1_tx_chan_timer`

## Requirements
- R1: The position runs from 0 to 192 and steps by one on each rising edge. With no frame sync, it returns to 0 after 192. At position 0, chan_num is 0 and bit_idx is 0. At position p from 1 to 192, chan_num is (p-1)/8+1 and bit_idx is (p-1)%8, where bit_idx 0 is the channel MSB.
- R2: A rising edge with fsync high puts the block at position 0 for the next bit time, whatever the current position.
- R3: chan_clk is high exactly when chan_num is between 1 and 24 and bit_idx is 7.
- R4: At position 0 (the framing bit), chan_clk and chan_blk are both low.
- R5: During channel n (1 to 24), chan_blk equals bit n-1 of the active gating mask.
- R6: A rising edge with mask_we high stores mask_wdata as the pending mask. The active mask takes the pending value only at the rising edge that enters position 0. A write made on that same edge waits for the following frame boundary.
- R7: A frame counter is 0 after reset and increases by one at each entry to position 0. link_clk is high only at position 0. When link_mode is 0 (4 kHz), link_clk is high in frames where the count is even. When link_mode is 1 (2 kHz), it is high in frames where the count modulo 4 is 0.
- R8: ser_q shows the value of ser_in taken at the most recent falling edge of clk.
- R9: While rst_n is low, the block is at position 0 with frame count 0, both masks clear and ser_q low. So chan_num, bit_idx, chan_clk and chan_blk read 0, and link_clk reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-cycle frame sync, forces the framing-bit position |
| ser_in | input | 1 | Transmit serial data, sampled on the falling edge |
| mask_we | input | 1 | Write enable for the gating mask |
| mask_wdata | input | 24 | New gating mask, bit n controls channel n+1 |
| link_mode | input | 1 | 0 selects the 4 kHz demand clock, 1 selects 2 kHz |
| chan_clk | output | 1 | High during the LSB of each channel |
| chan_blk | output | 1 | Per-channel gating level from the active mask |
| link_clk | output | 1 | Data-link demand pulse at the framing bit |
| ser_q | output | 1 | Sampled serial bit |
| chan_num | output | 5 | Current channel, 0 at the framing bit, otherwise 1 to 24 |
| bit_idx | output | 3 | Bit within the channel, 0 is the MSB |

## Verification
The assertions check on every cycle:
- that the position counter stays in range, wraps after 192 and obeys frame sync;
- that the channel clock appears only on bit 7;
- that both strobes stay low on the framing bit;
- that the demand clock appears only there;
- that the active mask holds still everywhere except at the frame boundary.

Only the bench scenarios can show the rest:
- that the gating level follows the right mask bit for each channel;
- that a mask write is delayed to the correct frame boundary, including a write on the boundary edge itself;
- that the demand clock picks the right frames in each mode;
- that the falling-edge sample carries the right data.

// File: rtl/t1_tx_chan_timer.sv
module t1_tx_chan_timer #(
  parameter int N_CH    = 24,
  parameter int CH_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fsync,
  input  logic                          ser_in,
  input  logic                          mask_we,
  input  logic [N_CH-1:0]               mask_wdata,
  input  logic                          link_mode,
  output logic                          chan_clk,
  output logic                          chan_blk,
  output logic                          link_clk,
  output logic                          ser_q,
  output logic [$clog2(N_CH+1)-1:0]     chan_num,
  output logic [$clog2(CH_BITS)-1:0]    bit_idx
);
  localparam int FRAME_LEN = N_CH * CH_BITS + 1;
  localparam int PW = $clog2(FRAME_LEN);
  localparam int CW = $clog2(N_CH + 1);
  localparam int BW = $clog2(CH_BITS);

  logic [PW-1:0]   pos, nxt, off;
  logic [N_CH-1:0] mask_pend, mask_act, sel_bits;
  logic [1:0]      fcnt;
  logic            in_chan, ser_neg;

  assign nxt = (fsync || pos == PW'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      fcnt      <= '0;
      mask_pend <= '0;
      mask_act  <= '0;
    end else begin
      pos <= nxt;
      if (nxt == '0) begin
        mask_act <= mask_pend;
        fcnt     <= fcnt + 2'd1;
      end
      if (mask_we) mask_pend <= mask_wdata;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ser_neg <= 1'b0;
    else        ser_neg <= ser_in;
  end

  assign in_chan  = (pos != '0);
  assign off      = pos - 1'b1;
  assign chan_num = in_chan ? CW'(off / PW'(CH_BITS)) + CW'(1) : '0;
  assign bit_idx  = in_chan ? BW'(off % PW'(CH_BITS)) : '0;
  assign sel_bits = mask_act >> (chan_num - CW'(1));

  assign chan_clk = in_chan && bit_idx == BW'(CH_BITS - 1);
  assign chan_blk = in_chan && sel_bits[0];
  assign link_clk = !in_chan && (link_mode ? fcnt == 2'd0 : !fcnt[0]);
  assign ser_q    = ser_neg;
endmodule

// File: rtl/t1_tx_chan_timer_chk.sv
module t1_tx_chan_timer_chk #(
  parameter int N_CH    = 24,
  parameter int CH_BITS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fsync,
  input logic [$clog2(N_CH*CH_BITS+1)-1:0] pos,
  input logic [N_CH-1:0]            mask_act,
  input logic                       chan_clk,
  input logic                       chan_blk,
  input logic                       link_clk,
  input logic [$clog2(N_CH+1)-1:0]  chan_num,
  input logic [$clog2(CH_BITS)-1:0] bit_idx
);
  localparam int LAST = N_CH * CH_BITS;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST); // R1
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos == LAST) |=> pos == 0); // R1
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos != LAST) |=> pos == $past(pos) + 1'b1); // R1
  AST_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> pos == 0); // R2
  AST_CHCLK_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk |-> (bit_idx == CH_BITS - 1 && chan_num != 0)); // R3
  AST_FBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chan_num == 0 |-> (!chan_clk && !chan_blk)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && pos != LAST) |=> $stable(mask_act)); // R6
  AST_LINK_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk |-> chan_num == 0); // R7
endmodule

bind t1_tx_chan_timer t1_tx_chan_timer_chk #(.N_CH(N_CH), .CH_BITS(CH_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .pos(pos), .mask_act(mask_act),
  .chan_clk(chan_clk), .chan_blk(chan_blk), .link_clk(link_clk),
  .chan_num(chan_num), .bit_idx(bit_idx)
);

// File: tb/t1_tx_chan_timer_tb.sv
module t1_tx_chan_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync = 1'b0, ser_in = 1'b0, mask_we = 1'b0, link_mode = 1'b0;
  logic [23:0] mask_wdata = '0;
  logic chan_clk, chan_blk, link_clk, ser_q;
  logic [4:0] chan_num;
  logic [2:0] bit_idx;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int m_pos = 0, m_fcnt = 0;
  logic [23:0] m_pend = '0, m_act = '0;
  bit last_fs = 1'b0;

  always #5 clk = ~clk;

  t1_tx_chan_timer dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .link_mode(link_mode),
    .chan_clk(chan_clk), .chan_blk(chan_blk), .link_clk(link_clk),
    .ser_q(ser_q), .chan_num(chan_num), .bit_idx(bit_idx)
  );

  function automatic int e_chan(int p);
    return (p == 0) ? 0 : (p - 1) / 8 + 1;
  endfunction
  function automatic int e_bit(int p);
    return (p == 0) ? 0 : (p - 1) % 8;
  endfunction
  function automatic bit e_link(int p, int fc, bit md);
    if (p != 0) return 1'b0;
    return md ? (fc % 4 == 0) : (fc % 2 == 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, m_pos, act, exp);
    end
  endtask

  task automatic cycle(bit fs, bit we, logic [23:0] wd, bit md, bit sin);
    int c;
    fsync = fs; mask_we = we; mask_wdata = wd; link_mode = md; ser_in = sin;
    #5;
    c = e_chan(m_pos);
    chk(last_fs ? "R2 chan_num" : "R1 chan_num", int'(chan_num), c);
    chk("R1 bit_idx", int'(bit_idx), e_bit(m_pos));
    chk("R3 chan_clk", int'(chan_clk), int'(c != 0 && e_bit(m_pos) == 7));
    chk(c == 0 ? "R4 chan_blk" : "R5 R6 chan_blk", int'(chan_blk),
        int'(c != 0 && m_act[c-1]));
    chk("R7 link_clk", int'(link_clk), int'(e_link(m_pos, m_fcnt, md)));
    chk("R8 ser_q", int'(ser_q), int'(sin));
    last_fs = fs;
    m_pos = (fs || m_pos == 192) ? 0 : m_pos + 1;
    if (m_pos == 0) begin m_act = m_pend; m_fcnt++; end
    if (we) m_pend = wd;
    @(posedge clk); #1;
  endtask

  task automatic run(int n, bit md, int fs_pct, int we_pct);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < fs_pct, ($urandom % 100) < we_pct,
            24'($urandom), md, 1'($urandom));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1544));
    #12;
    // R9 reset state
    chk("R9 chan_num", int'(chan_num), 0);
    chk("R9 bit_idx", int'(bit_idx), 0);
    chk("R9 chan_clk", int'(chan_clk), 0);
    chk("R9 chan_blk", int'(chan_blk), 0);
    chk("R9 link_clk", int'(link_clk), 1);
    chk("R9 ser_q", int'(ser_q), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    // R1 free-running wrap, mask written mid-frame (R6)
    for (int i = 0; i < 193 * 2; i++)
      cycle(0, i == 50, 24'hA5_0F_C3, 0, 1'($urandom));
    // R6 write on the boundary edge itself: waits an extra frame
    while (m_pos != 192) cycle(0, 0, '0, 0, 0);
    cycle(0, 1, 24'hFF_FF_FF, 0, 1);
    for (int i = 0; i < 193 * 2; i++) cycle(0, 0, '0, 0, 1'($urandom));
    // R2 fsync mid-frame and back-to-back
    for (int i = 0; i < 70; i++) cycle(0, 0, '0, 0, 0);
    cycle(1, 0, '0, 0, 1);
    cycle(1, 1, 24'h00_00_01, 0, 0);
    // R7 2 kHz mode over several frames
    run(193 * 6, 1, 0, 1);
    // random mix with occasional frame sync, both modes
    run(193 * 4, 0, 1, 2);
    run(193 * 4, 1, 1, 2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule